// File: doc/BRIEF.md
# ADC Cross-Check Diagnostic Engine

This block runs one diagnostic comparison at a time between two ADC result streams of a six-cell battery monitor. A host writes a small control register that holds a 3-bit test select and a GO bit. When GO is written as 1 and no test is running, the engine latches the select and the auxiliary channel number. It then waits for a fresh valid sample from each converter stream that the chosen test needs, and judges the result in one cycle.

Five comparisons are available. The first is a bounded main/aux delta on one cell. The second is an absolute floor on every active main cell result, used for open-wire detection on the voltage pins. The third is the same floor applied to one auxiliary result, used for open-wire detection on the balance pins. The fourth is a one-third ratio test for a balancing switch. The fifth is a bounded delta between the main and auxiliary GPIO results. Each test raises its own sticky done flag. Cell fail flags are reported per channel, and the GPIO test has a single fail flag.

Top module: `adc_xcheck`

## Requirements
- R1: A write with ctl_wdata[0]=1 while idle latches ctl_wdata[3:1] as the select and aux_sel as the channel. A write with ctl_wdata[0]=0 changes nothing.
- R2: ctl_rdata is {busy, select[2:0], 1'b0}. The GO bit always reads 0, and all outputs are 0 after reset.
- R3: Select codes 0, 6 and 7 start no test. busy stays 0, and no done or fail flag changes.
- R4: Code 1 checks cell channel ch, using the main result for ch and the aux word. It fails when |main-aux| is not below the scaled 5-bit threshold. On completion cell_fail is rewritten so that only bit ch may be 1, and done[0] is set.
- R5: Code 2 checks every cell i with active_mask[i]=1. Cell i fails when its main result is below the scaled 4-bit open-wire threshold. On completion cell_fail is rewritten (masked cells read 0) and done[1] is set.
- R6: Code 3 fails channel ch when the aux word is below the scaled 4-bit open-wire threshold. It rewrites cell_fail with only bit ch possible and sets done[2].
- R7: Code 4 passes channel ch when 3*aux < main[ch] and fails it otherwise. It rewrites cell_fail with only bit ch possible and sets done[3].
- R8: Code 5 fails when |gpio_main-gpio_aux| is not below the scaled 3-bit threshold. It rewrites gpio_fail, sets done[4] and leaves cell_fail unchanged.
- R9: Each threshold code is multiplied by 2^THR_SHIFT before the comparison, and every "below" comparison is strict.
- R10: After GO the engine needs one strobe from each required stream (codes 1 and 4: main_vld and aux_vld; code 2: main_vld; code 3: aux_vld; code 5: gpio_main_vld and gpio_aux_vld). A strobe counts only from the cycle after the GO write. The verdict, the done flag and the drop of busy appear one clock after the last counted strobe.
- R11: A GO written while busy is ignored, and the select and channel are kept.
- R12: Done flags stay set until cleared by a 1 on the matching done_clr bit. When a clear and a completion hit the same flag in one cycle, the completion wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | {select[2:0], GO} |
| ctl_rdata | output | 5 | {busy, select[2:0], 0} |
| done_clr | input | 5 | Per-flag clear, one bit per done flag |
| main_vld | input | 1 | Main cell result strobe |
| main_data | input | NCELL*DW | Main cell results, cell i at [i*DW +: DW] |
| aux_vld | input | 1 | Auxiliary cell result strobe |
| aux_data | input | DW | Auxiliary result for the selected channel |
| gpio_main_vld | input | 1 | Main GPIO result strobe |
| gpio_main_data | input | DW | Main GPIO result |
| gpio_aux_vld | input | 1 | Auxiliary GPIO result strobe |
| gpio_aux_data | input | DW | Auxiliary GPIO result |
| aux_sel | input | CW | Channel under test |
| active_mask | input | NCELL | Cells included in the code 2 test |
| thr_cell | input | 5 | Code 1 delta threshold |
| thr_ow | input | 4 | Open-wire floor threshold |
| thr_gpio | input | 3 | GPIO delta threshold |
| done | output | 5 | Sticky done flags, one per test |
| cell_fail | output | NCELL | Per-channel fail flags |
| gpio_fail | output | 1 | GPIO test fail flag |

## Verification
A host clear of a done flag can land on the same edge on which the engine completes that test, so the clear and the completion share one cycle. The bench provokes this by driving done_clr at the exact cycle of the evaluation edge, which is one clock after the last needed strobe. It judges the outcome by checking that the flag reads 1 afterwards, and that a later clear on its own still drops it. A second overlap is a GO write in the cycle a strobe arrives. Such a strobe must not count, and the engine must stay busy.

// File: rtl/adc_xcheck_pkg.sv
package adc_xcheck_pkg;
    localparam logic [2:0] SEL_CELL = 3'd1;
    localparam logic [2:0] SEL_VCOW = 3'd2;
    localparam logic [2:0] SEL_CBOW = 3'd3;
    localparam logic [2:0] SEL_FET  = 3'd4;
    localparam logic [2:0] SEL_GPIO = 3'd5;
    localparam int NDONE = 5;

    function automatic logic sel_runs(input logic [2:0] s);
        return (s >= SEL_CELL) && (s <= SEL_GPIO);
    endfunction

    function automatic logic [NDONE-1:0] sel_done_bit(input logic [2:0] s);
        logic [NDONE-1:0] r;
        r = '0;
        if (sel_runs(s)) r[s - 3'd1] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/xchk_ctrl.sv
module xchk_ctrl
    import adc_xcheck_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [3:0]    ctl_wdata,
    input  logic [CW-1:0] aux_sel,
    input  logic          main_vld,
    input  logic          aux_vld,
    input  logic          gpio_main_vld,
    input  logic          gpio_aux_vld,
    output logic          busy,
    output logic [2:0]    sel,
    output logic [CW-1:0] chan,
    output logic          cap_main,
    output logic          cap_aux,
    output logic          fire
);
    typedef struct packed {
        logic          busy;
        logic [2:0]    sel;
        logic [CW-1:0] chan;
        logic          have_m;
        logic          have_a;
    } st_t;

    st_t st_d, st_q;
    logic m_stb, a_stb, need_m, need_a;

    always_comb begin
        st_d   = st_q;
        m_stb  = (st_q.sel == SEL_GPIO) ? gpio_main_vld : main_vld;
        a_stb  = (st_q.sel == SEL_GPIO) ? gpio_aux_vld  : aux_vld;
        need_m = (st_q.sel != SEL_CBOW);
        need_a = (st_q.sel != SEL_VCOW);
        fire   = st_q.busy && (st_q.have_m || !need_m) && (st_q.have_a || !need_a);
        cap_main = st_q.busy && !fire && need_m && !st_q.have_m && m_stb;
        cap_aux  = st_q.busy && !fire && need_a && !st_q.have_a && a_stb;
        if (!st_q.busy) begin
            if (ctl_wr && ctl_wdata[0]) begin
                st_d.sel    = ctl_wdata[3:1];
                st_d.chan   = aux_sel;
                st_d.have_m = 1'b0;
                st_d.have_a = 1'b0;
                st_d.busy   = sel_runs(ctl_wdata[3:1]);
            end
        end else if (fire) begin
            st_d.busy = 1'b0;
        end else begin
            if (cap_main) st_d.have_m = 1'b1;
            if (cap_aux)  st_d.have_a = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign sel  = st_q.sel;
    assign chan = st_q.chan;
endmodule

// File: rtl/xchk_eval.sv
module xchk_eval
    import adc_xcheck_pkg::*;
#(
    parameter int NCELL     = 6,
    parameter int DW        = 12,
    parameter int THR_SHIFT = 4,
    parameter int CW        = 3
) (
    input  logic [2:0]          sel,
    input  logic [CW-1:0]       chan,
    input  logic [NCELL*DW-1:0] m_vec,
    input  logic [DW-1:0]       a_word,
    input  logic [DW-1:0]       gm_word,
    input  logic [DW-1:0]       ga_word,
    input  logic [NCELL-1:0]    mask,
    input  logic [4:0]          thr_cell,
    input  logic [3:0]          thr_ow,
    input  logic [2:0]          thr_gpio,
    output logic [NCELL-1:0]    cell_res,
    output logic                gpio_res
);
    localparam int XW = DW + 2;

    logic [DW-1:0] lim_cell, lim_ow, lim_gpio, gdiff;
    logic [XW-1:0] a_x3;

    assign lim_cell = DW'(thr_cell) << THR_SHIFT;
    assign lim_ow   = DW'(thr_ow)   << THR_SHIFT;
    assign lim_gpio = DW'(thr_gpio) << THR_SHIFT;
    assign a_x3     = {1'b0, a_word, 1'b0} + {2'b00, a_word};
    assign gdiff    = (gm_word > ga_word) ? gm_word - ga_word : ga_word - gm_word;
    assign gpio_res = !(gdiff < lim_gpio);

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        logic [DW-1:0] mv, dv;
        logic          hit, r;
        assign mv  = m_vec[i*DW +: DW];
        assign dv  = (mv > a_word) ? mv - a_word : a_word - mv;
        assign hit = (chan == CW'(i));
        always_comb begin
            case (sel)
                SEL_CELL: r = hit && !(dv < lim_cell);
                SEL_VCOW: r = mask[i] && (mv < lim_ow);
                SEL_CBOW: r = hit && (a_word < lim_ow);
                SEL_FET:  r = hit && !(a_x3 < {2'b00, mv});
                default:  r = 1'b0;
            endcase
        end
        assign cell_res[i] = r;
    end
endmodule

// File: rtl/adc_xcheck.sv
module adc_xcheck
    import adc_xcheck_pkg::*;
#(
    parameter int NCELL     = 6,
    parameter int DW        = 12,
    parameter int THR_SHIFT = 4,
    localparam int CW       = $clog2(NCELL)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic [3:0]          ctl_wdata,
    output logic [4:0]          ctl_rdata,
    input  logic [4:0]          done_clr,
    input  logic                main_vld,
    input  logic [NCELL*DW-1:0] main_data,
    input  logic                aux_vld,
    input  logic [DW-1:0]       aux_data,
    input  logic                gpio_main_vld,
    input  logic [DW-1:0]       gpio_main_data,
    input  logic                gpio_aux_vld,
    input  logic [DW-1:0]       gpio_aux_data,
    input  logic [CW-1:0]       aux_sel,
    input  logic [NCELL-1:0]    active_mask,
    input  logic [4:0]          thr_cell,
    input  logic [3:0]          thr_ow,
    input  logic [2:0]          thr_gpio,
    output logic [4:0]          done,
    output logic [NCELL-1:0]    cell_fail,
    output logic                gpio_fail
);
    typedef struct packed {
        logic [NCELL*DW-1:0] m_vec;
        logic [DW-1:0]       a_word;
        logic [DW-1:0]       gm_word;
        logic [DW-1:0]       ga_word;
        logic [NDONE-1:0]    done;
        logic [NCELL-1:0]    cfail;
        logic                gfail;
    } rs_t;

    rs_t rs_d, rs_q;
    logic          busy, cap_main, cap_aux, fire, gpio_res;
    logic [2:0]    sel;
    logic [CW-1:0] chan;
    logic [NCELL-1:0] cell_res;

    xchk_ctrl #(.CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .aux_sel(aux_sel), .main_vld(main_vld), .aux_vld(aux_vld),
        .gpio_main_vld(gpio_main_vld), .gpio_aux_vld(gpio_aux_vld),
        .busy(busy), .sel(sel), .chan(chan),
        .cap_main(cap_main), .cap_aux(cap_aux), .fire(fire)
    );

    xchk_eval #(.NCELL(NCELL), .DW(DW), .THR_SHIFT(THR_SHIFT), .CW(CW)) u_eval (
        .sel(sel), .chan(chan), .m_vec(rs_q.m_vec), .a_word(rs_q.a_word),
        .gm_word(rs_q.gm_word), .ga_word(rs_q.ga_word), .mask(active_mask),
        .thr_cell(thr_cell), .thr_ow(thr_ow), .thr_gpio(thr_gpio),
        .cell_res(cell_res), .gpio_res(gpio_res)
    );

    always_comb begin
        rs_d = rs_q;
        if (cap_main) begin
            rs_d.m_vec   = main_data;
            rs_d.gm_word = gpio_main_data;
        end
        if (cap_aux) begin
            rs_d.a_word  = aux_data;
            rs_d.ga_word = gpio_aux_data;
        end
        rs_d.done = rs_q.done & ~done_clr;
        if (fire) begin
            rs_d.done = rs_d.done | sel_done_bit(sel);
            if (sel == SEL_GPIO) rs_d.gfail = gpio_res;
            else                 rs_d.cfail = cell_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign ctl_rdata = {busy, sel, 1'b0};
    assign done      = rs_q.done;
    assign cell_fail = rs_q.cfail;
    assign gpio_fail = rs_q.gfail;
endmodule

// File: rtl/adc_xcheck_chk.sv
module adc_xcheck_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic [3:0] ctl_wdata,
    input logic [4:0] ctl_rdata,
    input logic [4:0] done_clr,
    input logic [4:0] done
);
    logic busy;
    assign busy = ctl_rdata[4];

    assert_go_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ctl_wr && ctl_wdata[0]) |=> (ctl_rdata[3:1] == $past(ctl_wdata[3:1])));

    assert_nogo_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_wdata[0]) |=> $stable(ctl_rdata[3:1]));

    assert_noop_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ctl_wr && ctl_wdata[0] && (ctl_wdata[3:1] == 3'd0 || ctl_wdata[3:1] >= 3'd6))
        |=> !busy);

    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_wr) |=> $stable(ctl_rdata[3:1]));

    assert_done_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((done & ~$past(done)) != 5'd0) |-> ($past(busy) && !busy));

    assert_one_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done & ~$past(done)));

    assert_clear_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr != 5'd0 && !busy) |=> ((done & $past(done_clr)) == 5'd0));
endmodule

bind adc_xcheck adc_xcheck_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .done_clr(done_clr), .done(done)
);

// File: tb/adc_xcheck_tb_top.sv
module adc_xcheck_tb_top;
    localparam int NCELL = 6;
    localparam int DW    = 12;
    localparam int SH    = 4;
    localparam int MAXV  = (1 << DW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 1'b0;
    logic [3:0] ctl_wdata = '0;
    logic [4:0] ctl_rdata;
    logic [4:0] done_clr = '0;
    logic main_vld = 1'b0, aux_vld = 1'b0, gm_vld = 1'b0, ga_vld = 1'b0;
    logic [NCELL*DW-1:0] main_data = '0;
    logic [DW-1:0] aux_data = '0, gm_data = '0, ga_data = '0;
    logic [2:0] aux_sel = '0;
    logic [NCELL-1:0] mask = '1;
    logic [4:0] thr_cell = '0;
    logic [3:0] thr_ow = '0;
    logic [2:0] thr_gpio = '0;
    logic [4:0] done;
    logic [NCELL-1:0] cell_fail;
    logic gpio_fail;

    int n_run = 0, n_bad = 0;
    bit finished = 0;
    int m_arr [NCELL];
    int a_v, gm_v, ga_v;
    logic [NCELL-1:0] exp_cf = '0;
    logic exp_gf = 1'b0;

    always #10 clk = ~clk;

    adc_xcheck dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .done_clr(done_clr),
        .main_vld(main_vld), .main_data(main_data), .aux_vld(aux_vld), .aux_data(aux_data),
        .gpio_main_vld(gm_vld), .gpio_main_data(gm_data),
        .gpio_aux_vld(ga_vld), .gpio_aux_data(ga_data),
        .aux_sel(aux_sel), .active_mask(mask), .thr_cell(thr_cell), .thr_ow(thr_ow),
        .thr_gpio(thr_gpio), .done(done), .cell_fail(cell_fail), .gpio_fail(gpio_fail)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int clampv(input int v);
        return (v < 0) ? 0 : ((v > MAXV) ? MAXV : v);
    endfunction

    function automatic logic [NCELL-1:0] model_cells(input logic [2:0] code);
        logic [NCELL-1:0] f = '0;
        int ch = int'(aux_sel);
        case (code)
            3'd1: f[ch] = !(iabs(m_arr[ch] - a_v) < (int'(thr_cell) << SH));
            3'd2: for (int i = 0; i < NCELL; i++)
                      f[i] = mask[i] && (m_arr[i] < (int'(thr_ow) << SH));
            3'd3: f[ch] = (a_v < (int'(thr_ow) << SH));
            3'd4: f[ch] = !(3 * a_v < m_arr[ch]);
            default: f = '0;
        endcase
        return f;
    endfunction

    function automatic logic model_gpio();
        return !(iabs(gm_v - ga_v) < (int'(thr_gpio) << SH));
    endfunction

    task automatic load_data();
        for (int i = 0; i < NCELL; i++) main_data[i*DW +: DW] = DW'(m_arr[i]);
        aux_data = DW'(a_v);
        gm_data  = DW'(gm_v);
        ga_data  = DW'(ga_v);
    endtask

    task automatic wr(input logic [2:0] code, input logic go);
        ctl_wr = 1'b1;
        ctl_wdata = {code, go};
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic clr_all();
        done_clr = 5'h1f;
        @(negedge clk);
        done_clr = 5'h00;
    endtask

    task automatic strobe(input logic [2:0] code);
        load_data();
        if (code == 3'd5) begin
            gm_vld = 1'b1; ga_vld = 1'b1;
        end else begin
            main_vld = (code != 3'd3);
            aux_vld  = (code != 3'd2);
        end
        @(negedge clk);
        main_vld = 1'b0; aux_vld = 1'b0; gm_vld = 1'b0; ga_vld = 1'b0;
    endtask

    task automatic run_and_check(input logic [2:0] code, input string req);
        logic [4:0] dbit;
        clr_all();
        wr(code, 1'b1);
        strobe(code);
        @(negedge clk);
        dbit = 5'd1 << (code - 3'd1);
        if (code == 3'd5) exp_gf = model_gpio();
        else              exp_cf = model_cells(code);
        check({req, " done"}, 32'(done), 32'(dbit));
        check({req, " cell_fail"}, 32'(cell_fail), 32'(exp_cf));
        check({req, " gpio_fail"}, 32'(gpio_fail), 32'(exp_gf));
        check({req, " busy"}, 32'(ctl_rdata[4]), 32'd0);
    endtask

    initial begin
        for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NCELL; i++) m_arr[i] = 0;
        a_v = 0; gm_v = 0; ga_v = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        check("R2 rdata reset", 32'(ctl_rdata), 32'd0);
        check("R2 done reset", 32'(done), 32'd0);
        check("R2 fail reset", 32'({gpio_fail, cell_fail}), 32'd0);

        // R1: write with GO=0 changes nothing
        wr(3'd3, 1'b0);
        @(negedge clk);
        check("R1 nogo select", 32'(ctl_rdata), 32'd0);

        // R3: no-op codes
        wr(3'd6, 1'b1);
        @(negedge clk);
        check("R3 code6 rdata", 32'(ctl_rdata), 32'b01100);
        wr(3'd0, 1'b1);
        main_vld = 1'b1; aux_vld = 1'b1;
        @(negedge clk);
        main_vld = 1'b0; aux_vld = 1'b0;
        @(negedge clk);
        check("R3 code0 idle", 32'(ctl_rdata), 32'd0);
        check("R3 code0 done", 32'(done), 32'd0);
        check("R3 code0 fail", 32'({gpio_fail, cell_fail}), 32'd0);

        // R10, R11: fresh samples only, GO while busy ignored
        m_arr = '{100, 200, 300, 400, 500, 600};
        a_v = 300; aux_sel = 3'd2; thr_cell = 5'd1;
        load_data();
        main_vld = 1'b1; aux_vld = 1'b1;
        wr(3'd1, 1'b1);
        main_vld = 1'b0; aux_vld = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 stale strobe ignored busy", 32'(ctl_rdata), 32'b10010);
        check("R10 stale strobe no done", 32'(done), 32'd0);
        aux_sel = 3'd4;
        wr(3'd5, 1'b1);
        @(negedge clk);
        check("R11 go while busy", 32'(ctl_rdata), 32'b10010);
        main_vld = 1'b1;
        @(negedge clk);
        main_vld = 1'b0;
        @(negedge clk);
        check("R10 one stream only busy", 32'(ctl_rdata[4]), 32'd1);
        aux_vld = 1'b1;
        @(negedge clk);
        aux_vld = 1'b0;
        check("R10 not yet done", 32'(done), 32'd0);
        @(negedge clk);
        check("R10 done after last strobe", 32'(done), 32'b00001);
        check("R4 R11 kept channel pass", 32'(cell_fail), 32'd0);

        // R9: strict boundaries
        aux_sel = 3'd1; thr_cell = 5'd2;
        m_arr[1] = 1000; a_v = 1000 + (2 << SH);
        run_and_check(3'd1, "R9 R4 delta equal limit");
        a_v = 1000 + (2 << SH) - 1;
        run_and_check(3'd1, "R9 R4 delta below limit");
        m_arr[1] = 900; a_v = 300;
        run_and_check(3'd4, "R9 R7 ratio equal");
        m_arr[1] = 901;
        run_and_check(3'd4, "R7 ratio pass");

        // R5 with mask, R6, R8 directed
        m_arr = '{10, 500, 5, 500, 500, 500};
        thr_ow = 4'd1; mask = 6'b111011;
        run_and_check(3'd2, "R5 masked cell");
        aux_sel = 3'd5; a_v = 15;
        run_and_check(3'd3, "R6 cb open wire");
        gm_v = 1000; ga_v = 1000 - (3 << SH); thr_gpio = 3'd3;
        run_and_check(3'd5, "R8 gpio equal limit");

        // R12: clear and completion in same cycle
        clr_all();
        wr(3'd2, 1'b1);
        load_data();
        main_vld = 1'b1;
        @(negedge clk);
        main_vld = 1'b0;
        done_clr = 5'b00010;
        @(negedge clk);
        done_clr = 5'b00000;
        check("R12 set wins over clear", 32'(done), 32'b00010);
        repeat (4) @(negedge clk);
        check("R12 sticky", 32'(done), 32'b00010);
        done_clr = 5'b00010;
        @(negedge clk);
        done_clr = 5'b00000;
        check("R12 clear alone", 32'(done), 32'd0);

        // Random mix
        mask = '1;
        for (int it = 0; it < 60; it++) begin
            logic [2:0] code;
            code = 3'(1 + ($urandom % 5));
            aux_sel = 3'($urandom % NCELL);
            mask = NCELL'($urandom);
            thr_cell = 5'($urandom); thr_ow = 4'($urandom); thr_gpio = 3'($urandom);
            for (int i = 0; i < NCELL; i++)
                m_arr[i] = (code == 3'd2) ? int'($urandom % 400) : int'($urandom % (MAXV + 1));
            case (code)
                3'd1: a_v = clampv(m_arr[aux_sel] + int'($urandom % 1000) - 500);
                3'd3: a_v = int'($urandom % 400);
                3'd4: a_v = int'($urandom % (m_arr[aux_sel] / 2 + 2));
                default: a_v = int'($urandom % (MAXV + 1));
            endcase
            gm_v = int'($urandom % (MAXV + 1));
            ga_v = clampv(gm_v + int'($urandom % 300) - 150);
            case (code)
                3'd1: run_and_check(code, "R4 random");
                3'd2: run_and_check(code, "R5 random");
                3'd3: run_and_check(code, "R6 random");
                3'd4: run_and_check(code, "R7 random");
                default: run_and_check(code, "R8 random");
            endcase
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule